// File: doc/BRIEF.md
# Snooze Sleep-Mode Sequencer

This block puts a small synchronous storage slice into a retention sleep state and brings it back out. A sleep request arrives with no timing relation to the clock. It is passed through a synchronizer. Once the synchronized request is high, the sequencer closes an input gate, so chip select, burst start, advance and write are all ignored. It also forces the read-data drivers off and raises a sleep-status flag for the surrounding controller.

When the request is removed, the block stays in sleep for a fixed hold-off after the synchronizer has seen the request low. Only then does it open the input gate again. Storage contents are kept through sleep. Any burst that was open when sleep began is dropped, so the first useful access after wake-up must be a fresh burst start.

The storage slice keeps a burst base address and a burst offset. The offset steps through a group of `2**BURST_W` words, either in linear order or in interleaved order.

Top module: `snz_sleep_seq`

## Requirements
- R1: After reset, `gate_en` is 1, `hiz_force` is 0, `sleep_flag` is 0 and `rdata_oe` is 0.
- R2: Let E be the first clock edge that samples `sleep_req` high. After E the block is still awake. After edge E+1, `gate_en` is 0 and both `hiz_force` and `sleep_flag` are 1.
- R3: While `gate_en` is 0, `cs`, `start`, `adv` and `we` have no effect: no word is written, the burst address does not move and `rdata` holds its value. This holds even with `cs` high.
- R4: While `hiz_force` is 1, `rdata_oe` is 0.
- R5: Let E be the first edge that samples `sleep_req` low after sleep. `gate_en` stays 0 after edges E through E+3, and returns to 1 after edge E+4, with both flags back at 0.
- R6: A request that is high for only one sampling edge still completes the entry sequence of R2, and then the full exit sequence of R5.
- R7: A burst open at sleep entry is dropped. After wake-up, `rdata_oe` is 0 and `adv` has no effect until a new `start`.
- R8: Words written before sleep read back unchanged after wake-up.
- R9: A `start` with `cs` high loads `addr` as the burst base and the offset as 0. With `we` high, it also writes `wdata` there; `rdata` shows the word at the current burst address and `rdata_oe` is 1 while a burst is open and the block is awake. Each `adv` (with `cs` high) increments the offset modulo 4. The low 2 address bits are base+offset when `INTERLEAVE`=0, or base XOR offset when `INTERLEAVE`=1. A write with `adv` lands at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | Sleep request, asynchronous to clk |
| cs | input | 1 | Chip select for storage access |
| start | input | 1 | Begin a burst at `addr` |
| adv | input | 1 | Advance the open burst |
| we | input | 1 | Write `wdata` at the accessed address |
| addr | input | ADDR_W | Burst start address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Word at the current burst address |
| rdata_oe | output | 1 | Read-data drive enable |
| gate_en | output | 1 | Synchronous inputs are being sampled |
| hiz_force | output | 1 | Data drivers forced to high impedance |
| sleep_flag | output | 1 | Block is in, entering or leaving sleep |

## Verification
The checker watches several properties on every cycle:
- drivers stay off whenever the high-impedance force is up;
- `rdata` is frozen across every gated cycle;
- an open burst is gone one cycle after gating begins;
- a request captured two edges earlier always means gating;
- wake-up only follows a low request.

The exact exit count of four edges, and the one-edge pulse that must still run the full sequence, can only be shown by the bench's cycle-stamped scenarios. The same goes for retention, for the ignored write during sleep, and for the linear wrap of the burst offset, all of which the bench checks by reading data back.

// File: rtl/snz_pkg.sv
package snz_pkg;
   typedef enum logic [1:0] {
      SNZ_AWAKE  = 2'd0,
      SNZ_ASLEEP = 2'd1,
      SNZ_WAKING = 2'd2
   } snz_state_e;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
   import snz_pkg::*;
#(
   parameter int WAKE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   output logic gate_en,
   output logic sleep_flag
);
   localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

   snz_state_e       state;
   logic [CNT_W-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SNZ_AWAKE;
         hold_cnt <= '0;
      end else begin
         case (state)
            SNZ_AWAKE:  if (req_s) state <= SNZ_ASLEEP;
            SNZ_ASLEEP: if (!req_s) begin
               state    <= SNZ_WAKING;
               hold_cnt <= CNT_W'(WAKE_CYC - 1);
            end
            SNZ_WAKING: begin
               if (req_s)              state <= SNZ_ASLEEP;
               else if (hold_cnt == '0) state <= SNZ_AWAKE;
               else                     hold_cnt <= hold_cnt - 1'b1;
            end
            default: state <= SNZ_AWAKE;
         endcase
      end
   end

   // the synchronized request gates at once; the state holds the gate through exit
   assign sleep_flag = req_s || (state != SNZ_AWAKE);
   assign gate_en    = !sleep_flag;
endmodule

// File: rtl/snz_store.sv
module snz_store #(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int BURST_W    = 2,
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_en,
   input  logic              hiz,
   input  logic              cs,
   input  logic              start,
   input  logic              adv,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0]  mem [DEPTH];
   logic [ADDR_W-1:0]  base, nxt_base, cur_addr, nxt_addr;
   logic [BURST_W-1:0] ofs, nxt_ofs;
   logic               open_q, act;

   assign act      = gate_en && cs && (start || (adv && open_q));
   assign nxt_base = start ? addr : base;
   assign nxt_ofs  = start ? '0 : ofs + 1'b1;

   generate
      if (INTERLEAVE) begin : g_ilv
         assign cur_addr = {base[ADDR_W-1:BURST_W], base[BURST_W-1:0] ^ ofs};
         assign nxt_addr = {nxt_base[ADDR_W-1:BURST_W], nxt_base[BURST_W-1:0] ^ nxt_ofs};
      end else begin : g_lin
         assign cur_addr = {base[ADDR_W-1:BURST_W], base[BURST_W-1:0] + ofs};
         assign nxt_addr = {nxt_base[ADDR_W-1:BURST_W], nxt_base[BURST_W-1:0] + nxt_ofs};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base   <= '0;
         ofs    <= '0;
         open_q <= 1'b0;
      end else if (!gate_en) begin
         open_q <= 1'b0;
      end else if (act) begin
         base   <= nxt_base;
         ofs    <= nxt_ofs;
         open_q <= 1'b1;
      end
   end

   // storage has no reset: contents survive sleep and reset alike
   always_ff @(posedge clk) begin
      if (act && we) mem[nxt_addr] <= wdata;
   end

   assign rdata    = mem[cur_addr];
   assign rdata_oe = open_q && !hiz;
endmodule

// File: rtl/snz_sleep_seq.sv
module snz_sleep_seq #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int BURST_W     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int WAKE_CYC    = 2,
   parameter bit INTERLEAVE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req,
   input  logic              cs,
   input  logic              start,
   input  logic              adv,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              gate_en,
   output logic              hiz_force,
   output logic              sleep_flag
);
   initial begin
      if (SYNC_STAGES < 2)     $error("snz_sleep_seq: SYNC_STAGES must be at least 2");
      if (WAKE_CYC < 1)        $error("snz_sleep_seq: WAKE_CYC must be at least 1");
      if (BURST_W < 1 || BURST_W > ADDR_W)
                               $error("snz_sleep_seq: BURST_W must lie in 1..ADDR_W");
      if (ADDR_W > 12)         $error("snz_sleep_seq: ADDR_W too large for this slice");
   end

   logic req_s;

   snz_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(sleep_req), .q(req_s)
   );

   snz_fsm #(.WAKE_CYC(WAKE_CYC)) i_fsm (
      .clk(clk), .rst_n(rst_n), .req_s(req_s),
      .gate_en(gate_en), .sleep_flag(sleep_flag)
   );

   assign hiz_force = sleep_flag;

   snz_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W), .INTERLEAVE(INTERLEAVE)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .hiz(hiz_force),
      .cs(cs), .start(start), .adv(adv), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );
endmodule

// File: rtl/snz_checks.sv
module snz_checks #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep_req,
   input logic              gate_en,
   input logic              hiz_force,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_oe
);
   AST_NO_DRIVE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_force |-> !rdata_oe); // R4

   AST_FROZEN_WHILE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_en |=> $stable(rdata)); // R3

   AST_BURST_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en) |=> !rdata_oe); // R7

   AST_EXIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> (!$past(sleep_req) && !$past(sleep_req, 2))); // R5

   generate
      if (SYNC_STAGES == 2) begin : g_entry
         AST_ENTRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sleep_req, 2) |-> !gate_en); // R2
      end
   endgenerate
endmodule

bind snz_sleep_seq snz_checks #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_checks (
   .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .gate_en(gate_en),
   .hiz_force(hiz_force), .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/test_snz_sleep_seq.sv
module test_snz_sleep_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0, cs = 1'b0, start = 1'b0, adv = 1'b0, we = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rdata_oe, gate_en, hiz_force, sleep_flag;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   snz_sleep_seq i_snz_sleep_seq (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cs(cs), .start(start),
      .adv(adv), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
      .rdata_oe(rdata_oe), .gate_en(gate_en), .hiz_force(hiz_force),
      .sleep_flag(sleep_flag)
   );

   typedef struct packed {
      logic       req, cs, st, adv, we;
      logic [3:0] addr;
      logic [7:0] wd;
      logic       gate, slp, oe, chk;
      logic [7:0] rd;
      logic [3:0] rq;
   } vec_t;

   // one row per clock edge; expectations hold just after that edge
   localparam vec_t VEC [18] = '{
      '{0,1,1,0,1,4'h4,8'hA1, 1,0,1,1,8'hA1, 4'd9}, // R9 start+write
      '{0,1,0,1,1,4'h0,8'hB2, 1,0,1,1,8'hB2, 4'd9}, // R9 adv write
      '{0,1,0,1,1,4'h0,8'hC3, 1,0,1,1,8'hC3, 4'd9},
      '{0,1,0,1,1,4'h0,8'hD4, 1,0,1,1,8'hD4, 4'd9},
      '{0,1,0,1,0,4'h0,8'h00, 1,0,1,1,8'hA1, 4'd9}, // R9 linear wrap
      '{0,1,1,0,0,4'h6,8'h00, 1,0,1,1,8'hC3, 4'd9},
      '{1,0,0,0,0,4'h0,8'h00, 1,0,1,1,8'hC3, 4'd2}, // R2 still awake after E
      '{1,0,0,0,0,4'h0,8'h00, 0,1,0,0,8'h00, 4'd2}, // R2 asleep after E+1
      '{1,1,1,0,1,4'h6,8'hEE, 0,1,0,0,8'h00, 4'd3}, // R3 ignored write
      '{0,1,0,1,1,4'h0,8'hFF, 0,1,0,0,8'h00, 4'd3}, // R3 ignored adv, R5 edge E
      '{0,0,0,0,0,4'h0,8'h00, 0,1,0,0,8'h00, 4'd4}, // R4
      '{0,0,0,0,0,4'h0,8'h00, 0,1,0,0,8'h00, 4'd4},
      '{0,0,0,0,0,4'h0,8'h00, 0,1,0,0,8'h00, 4'd5}, // R5 E+3 still gated
      '{0,0,0,0,0,4'h0,8'h00, 1,0,0,0,8'h00, 4'd5}, // R5 E+4 awake
      '{0,1,0,1,0,4'h0,8'h00, 1,0,0,0,8'h00, 4'd7}, // R7 adv without start
      '{0,1,1,0,0,4'h6,8'h00, 1,0,1,1,8'hC3, 4'd8}, // R8 retained, EE absent
      '{0,1,1,0,0,4'h7,8'h00, 1,0,1,1,8'hD4, 4'd8},
      '{0,1,1,0,0,4'h5,8'h00, 1,0,1,1,8'hB2, 4'd8}
   };

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_flags(input string tag, input logic g, input logic s, input logic o);
      check(tag, "gate_en", gate_en, g);
      check(tag, "sleep_flag", sleep_flag, s);
      check(tag, "hiz_force", hiz_force, s);
      check(tag, "rdata_oe", rdata_oe, o);
   endtask

   task automatic tick_and_settle();
      @(posedge clk);
      #5;
   endtask

   task automatic run_all();
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      tick_and_settle();
      check_flags("R1", 1'b1, 1'b0, 1'b0);

      foreach (VEC[i]) begin
         @(negedge clk);
         sleep_req = VEC[i].req; cs = VEC[i].cs; start = VEC[i].st;
         adv = VEC[i].adv; we = VEC[i].we; addr = VEC[i].addr; wdata = VEC[i].wd;
         tick_and_settle();
         check_flags($sformatf("R%0d row%0d", VEC[i].rq, i), VEC[i].gate, VEC[i].slp, VEC[i].oe);
         if (VEC[i].chk) check($sformatf("R%0d row%0d", VEC[i].rq, i), "rdata", rdata, VEC[i].rd);
      end

      // R6: one-edge request pulse runs the full entry and exit
      @(negedge clk);
      cs = 1'b0; start = 1'b0; adv = 1'b0; we = 1'b0; sleep_req = 1'b1;
      tick_and_settle();                       // edge E
      check("R6", "gate_en after E", gate_en, 1);
      @(negedge clk) sleep_req = 1'b0;
      tick_and_settle();                       // E+1, first low sample
      check("R6", "gate_en after E+1", gate_en, 0);
      check("R6", "sleep_flag after E+1", sleep_flag, 1);
      for (int k = 2; k <= 4; k++) begin
         tick_and_settle();
         check("R6", $sformatf("gate_en after E+%0d", k), gate_en, 0);
      end
      tick_and_settle();                       // E+5 = low sample + 4
      check_flags("R6", 1'b1, 1'b0, 1'b0);

      // R8: storage still intact after the second sleep
      @(negedge clk) begin cs = 1'b1; start = 1'b1; addr = 4'h4; end
      tick_and_settle();
      check("R8", "rdata addr4", rdata, 8'hA1);
      @(negedge clk) begin cs = 1'b0; start = 1'b0; end
   endtask

   initial begin
      fork
         run_all();
         begin
            #(20 * 5000);
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule